// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the slave end of a three-wire serial link: an active-low chip select, a serial clock, and one data line that is shared for both directions. It gives an external controller access to a small bank of 8-bit configuration registers. Every frame is 16 bits long. The first two bits are an opcode, the next six are a register address and the last eight are a data byte. The four opcodes are idle (no operation), store, fetch, and a global restore of every register to its power-up value. A fetch returns the addressed byte on the shared line during the clocks that follow the command, while chip select stays low. The block drives the line only in that window.

The serial clock, chip select and incoming data are brought into the system clock domain through a two-flop synchronizer, and edges are detected there. A state machine handles the frame. Its states are ST_IDLE (chip select high), ST_SHIFT (collecting bits), ST_RD_ARM (a fetch has been decoded and the first falling edge is awaited), ST_RD_DRIVE (read data on the line) and ST_HOLD (frame consumed; extra clocks are ignored). Its transitions are:
- chip select falling: IDLE→SHIFT.
- 16th rising edge: SHIFT→RD_ARM for a fetch, SHIFT→HOLD for the other opcodes.
- first falling edge: RD_ARM→RD_DRIVE.
- chip select rising: any state→IDLE.

The register bank holds sixteen writable bytes and one read-only status byte built from live inputs. The control byte holds two request flags that clear themselves when the matching completion pulse arrives. All writable contents are exported on a flat bus for the functions they configure.

Top module: `tri_wire_regslave`

## Requirements
- R1: A frame is 16 bits, most significant first, sampled on rising serial-clock edges. Bits 15:14 are the opcode, bits 13:8 the address and bits 7:0 the data byte.
- R2: Opcode 01 (store) to a writable address (0x00 to 0x03 or 0x05 to 0x10) loads the data byte into that register once the 16th bit arrives. Register k of that list, counted from zero in ascending address order, appears on `cfg_flat[8k+7:8k]`.
- R3: Opcode 10 (fetch) returns the addressed byte. Starting at the first falling edge after the 16th bit, one bit per falling edge is placed on `sdio_o`, most significant first, with `sdio_oe` high. The byte repeats every 8 clocks until chip select rises.
- R4: Opcode 00 changes no register and never drives the line.
- R5: Opcode 11 returns every writable register to its default, including both request flags. The defaults are 0x64 at address 0x05 and 0x00 elsewhere.
- R6: `sdio_oe` is low while chip select is high and during any frame that is not a fetch response.
- R7: Address 0x1A reads as {lock, gain_hi, xtal_ok, 0, 0, 0, pcal_done, fcal_done}, from bit 7 down to bit 0, taken from the status inputs. A store to 0x1A has no effect.
- R8: Bit 3 of address 0x01 (polling calibration request) clears on a `pcal_ack` pulse, and bit 2 (FSK calibration request) clears on an `fcal_ack` pulse. Other bits are unaffected. A store in the same cycle wins.
- R9: Stores to addresses outside the writable set and outside 0x1A are ignored, and fetches from them return 0x00.
- R10: If chip select rises before the 16th bit, the frame is dropped with no register effect, and the next frame is counted from its first bit.
- R11: After reset every writable register holds its default and `sdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Data line value to drive |
| sdio_oe | output | 1 | Pad output enable for the data line |
| st_lock | input | 1 | Status: synthesizer locked |
| st_gain_hi | input | 1 | Status: high-gain state |
| st_xtal_ok | input | 1 | Status: reference clock alive |
| st_pcal_done | input | 1 | Status: polling calibration done |
| st_fcal_done | input | 1 | Status: FSK calibration done |
| pcal_ack | input | 1 | Pulse: polling calibration finished |
| fcal_ack | input | 1 | Pulse: FSK calibration finished |
| cfg_flat | output | 128 | All writable registers, index k at bits 8k+7:8k |

## Verification
The assertions assume two things about the inputs. First, chip select and the serial data bit only change while the serial clock is low. Second, each serial-clock phase lasts several system clocks, so that a rising edge and a chip-select change never reach the synchronized domain in the same cycle. The bench meets both assumptions. It holds each serial half-period at six system clocks, changes data and chip select only in the low phase, and waits a full half-period before and after chip select moves. Random opcodes, addresses and status values are mixed with directed cases: aborted frames, repeated read-out, store to status, and the self-clearing requests.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 6;
    localparam int FRAME_W  = 16;
    localparam int CNT_W    = $clog2(FRAME_W);
    localparam int NUM_CFG  = 16;
    localparam int IDX_W    = $clog2(NUM_CFG);
    localparam int CTRL_IDX = 1;
    localparam int PCAL_BIT = 3;
    localparam int FCAL_BIT = 2;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 6'h1A;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_WR  = 2'b01,
        CMD_RD  = 2'b10,
        CMD_CLR = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_RD_ARM,
        ST_RD_DRIVE,
        ST_HOLD
    } fsm_e;

    function automatic logic cfg_hit(input logic [ADDR_W-1:0] a);
        return (a <= 6'h03) || ((a >= 6'h05) && (a <= 6'h10));
    endfunction

    function automatic logic [IDX_W-1:0] cfg_index(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] t;
        t = (a <= 6'h03) ? a : (a - 6'd1);
        return t[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
        if (gs == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[gs] <= RST_VAL;
                else        stage_q[gs] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[gs] <= RST_VAL;
                else        stage_q[gs] <= stage_q[gs-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/twr_frame.sv
module twr_frame
    import twr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              wr_en,
    output logic              clr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              dout,
    output logic              doe
);
    fsm_e               state_q, state_d;
    logic               sclk_q;
    logic               rise, fall;
    logic [FRAME_W-2:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  tx_q;
    logic [FRAME_W-1:0] frame;
    cmd_e               cmd;
    logic               commit;

    assign rise   = sclk_s & ~sclk_q;
    assign fall   = ~sclk_s & sclk_q;
    assign frame  = {shreg_q, din_s};
    assign cmd    = cmd_e'(frame[FRAME_W-1 -: 2]);
    assign addr   = frame[FRAME_W-3 -: ADDR_W];
    assign wdata  = frame[DATA_W-1:0];
    assign commit = (state_q == ST_SHIFT) && rise && (cnt_q == CNT_W'(FRAME_W-1));
    assign wr_en  = commit && (cmd == CMD_WR);
    assign clr_en = commit && (cmd == CMD_CLR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (!cs_s) state_d = ST_SHIFT;
            ST_SHIFT:    if (cs_s) state_d = ST_IDLE;
                         else if (commit) state_d = (cmd == CMD_RD) ? ST_RD_ARM : ST_HOLD;
            ST_RD_ARM:   if (cs_s) state_d = ST_IDLE;
                         else if (fall) state_d = ST_RD_DRIVE;
            ST_RD_DRIVE: if (cs_s) state_d = ST_IDLE;
            ST_HOLD:     if (cs_s) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        doe  = 1'b0;
        dout = 1'b0;
        unique case (state_q)
            ST_RD_DRIVE: begin
                doe  = 1'b1;
                dout = tx_q[DATA_W-1];
            end
            default: begin
                doe  = 1'b0;
                dout = 1'b0;
            end
        endcase
    end

    // shift path and read-out register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shreg_q <= '0;
            cnt_q   <= '0;
            tx_q    <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (state_q != ST_SHIFT) begin
                cnt_q <= '0;
            end else if (rise) begin
                shreg_q <= frame[FRAME_W-2:0];
                cnt_q   <= cnt_q + 1'b1;
            end
            if (commit && (cmd == CMD_RD)) begin
                tx_q <= rd_byte;
            end else if ((state_q == ST_RD_DRIVE) && fall) begin
                tx_q <= {tx_q[DATA_W-2:0], tx_q[DATA_W-1]};
            end
        end
    end

    AST_OE_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !doe); // R6
    AST_OE_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doe) |-> $past(fall)); // R3
    AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !(wr_en || clr_en)); // R10

endmodule

// File: rtl/twr_regbank.sv
module twr_regbank
    import twr_pkg::*;
#(
    parameter logic [NUM_CFG*DATA_W-1:0] DEFAULTS = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      clr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      pcal_ack,
    input  logic                      fcal_ack,
    input  logic                      st_lock,
    input  logic                      st_gain_hi,
    input  logic                      st_xtal_ok,
    input  logic                      st_pcal_done,
    input  logic                      st_fcal_done,
    output logic [DATA_W-1:0]         rd_byte,
    output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
    logic [NUM_CFG-1:0] wr_sel;
    logic [DATA_W-1:0]  reg_arr [NUM_CFG];
    logic [IDX_W-1:0]   idx;
    logic               hit;

    assign hit = cfg_hit(addr);
    assign idx = cfg_index(addr);

    always_comb begin
        wr_sel = '0;
        if (wr_en && hit) wr_sel[idx] = 1'b1;
    end

    for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_reg
        localparam logic [DATA_W-1:0] RV = DEFAULTS[gi*DATA_W +: DATA_W];
        logic [DATA_W-1:0] r_q;
        if (gi == CTRL_IDX) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          r_q <= RV;
                else if (clr_en)     r_q <= RV;
                else if (wr_sel[gi]) r_q <= wdata;
                else begin
                    if (pcal_ack) r_q[PCAL_BIT] <= 1'b0;
                    if (fcal_ack) r_q[FCAL_BIT] <= 1'b0;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          r_q <= RV;
                else if (clr_en)     r_q <= RV;
                else if (wr_sel[gi]) r_q <= wdata;
            end
        end
        assign reg_arr[gi] = r_q;
        assign cfg_flat[gi*DATA_W +: DATA_W] = r_q;
    end

    always_comb begin
        if (addr == STATUS_ADDR)
            rd_byte = {st_lock, st_gain_hi, st_xtal_ok, 3'b000, st_pcal_done, st_fcal_done};
        else if (hit)
            rd_byte = reg_arr[idx];
        else
            rd_byte = '0;
    end

    AST_CLR_TO_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (cfg_flat == DEFAULTS)); // R5
    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit && !pcal_ack && !fcal_ack) |=> $stable(cfg_flat)); // R9
    AST_PCAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pcal_ack && !wr_en && !clr_en) |=> !cfg_flat[CTRL_IDX*DATA_W+PCAL_BIT]); // R8
    AST_FCAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (fcal_ack && !wr_en && !clr_en) |=> !cfg_flat[CTRL_IDX*DATA_W+FCAL_BIT]); // R8

endmodule

// File: rtl/tri_wire_regslave.sv
module tri_wire_regslave
    import twr_pkg::*;
#(
    parameter logic [NUM_CFG*DATA_W-1:0] CFG_DEFAULTS =
        128'h0000_0000_0000_0000_0000_0064_0000_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      sclk,
    input  logic                      sdio_i,
    output logic                      sdio_o,
    output logic                      sdio_oe,
    input  logic                      st_lock,
    input  logic                      st_gain_hi,
    input  logic                      st_xtal_ok,
    input  logic                      st_pcal_done,
    input  logic                      st_fcal_done,
    input  logic                      pcal_ack,
    input  logic                      fcal_ack,
    output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
    logic [2:0]        pins_s;
    logic              wr_en, clr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rd_byte;

    twr_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdio_i}),
        .q     (pins_s)
    );

    twr_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .din_s   (pins_s[0]),
        .rd_byte (rd_byte),
        .wr_en   (wr_en),
        .clr_en  (clr_en),
        .addr    (addr),
        .wdata   (wdata),
        .dout    (sdio_o),
        .doe     (sdio_oe)
    );

    twr_regbank #(.DEFAULTS(CFG_DEFAULTS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .clr_en       (clr_en),
        .addr         (addr),
        .wdata        (wdata),
        .pcal_ack     (pcal_ack),
        .fcal_ack     (fcal_ack),
        .st_lock      (st_lock),
        .st_gain_hi   (st_gain_hi),
        .st_xtal_ok   (st_xtal_ok),
        .st_pcal_done (st_pcal_done),
        .st_fcal_done (st_fcal_done),
        .rd_byte      (rd_byte),
        .cfg_flat     (cfg_flat)
    );

endmodule

// File: tb/tri_wire_regslave_bench.sv
module tri_wire_regslave_bench;

    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
    logic sdio_o, sdio_oe;
    logic st_lock = 0, st_gain_hi = 0, st_xtal_ok = 0, st_pcal_done = 0, st_fcal_done = 0;
    logic pcal_ack = 0, fcal_ack = 0;
    logic [127:0] cfg_flat;

    int n_chk = 0, n_bad = 0, oe_viol = 0, cyc = 0;
    logic rd_window = 1'b0;
    logic done = 1'b0;
    logic [7:0] mdl [16];

    always #10 clk = ~clk;

    tri_wire_regslave u_tri_wire_regslave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .st_lock(st_lock), .st_gain_hi(st_gain_hi),
        .st_xtal_ok(st_xtal_ok), .st_pcal_done(st_pcal_done), .st_fcal_done(st_fcal_done),
        .pcal_ack(pcal_ack), .fcal_ack(fcal_ack), .cfg_flat(cfg_flat)
    );

    always @(negedge clk) begin
        cyc++;
        if (rst_n && sdio_oe && !rd_window) oe_viol++;
        if (cyc > 190000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic hit(input logic [5:0] a);
        return (a <= 6'h03) || (a >= 6'h05 && a <= 6'h10);
    endfunction
    function automatic int idx(input logic [5:0] a);
        return (a <= 6'h03) ? int'(a) : int'(a) - 1;
    endfunction
    function automatic logic [7:0] status_byte();
        return {st_lock, st_gain_hi, st_xtal_ok, 3'b000, st_pcal_done, st_fcal_done};
    endfunction
    function automatic logic [7:0] exp_read(input logic [5:0] a);
        if (a == 6'h1A) return status_byte();
        if (hit(a)) return mdl[idx(a)];
        return 8'h00;
    endfunction
    function automatic logic [127:0] exp_flat();
        logic [127:0] f;
        for (int i = 0; i < 16; i++) f[i*8 +: 8] = mdl[i];
        return f;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        mdl[4] = 8'h64;
    endtask

    // nbits frame bits, then rd_bits read-out clocks; got holds up to 16 returned bits
    task automatic xfer(input logic [15:0] w, input int nbits, input int rd_bits, output logic [15:0] got);
        got = '0;
        @(negedge clk);
        cs_n = 1'b0;
        wclk(H);
        for (int i = 0; i < nbits; i++) begin
            sdio_i = w[15-i];
            wclk(H);
            sclk = 1'b1;
            wclk(H);
            if (i == 15 && w[15:14] == 2'b10) rd_window = 1'b1;
            sclk = 1'b0;
        end
        for (int j = 0; j < rd_bits; j++) begin
            wclk(H);
            got[15-j] = sdio_oe ? sdio_o : 1'bx;
            sclk = 1'b1;
            wclk(H);
            sclk = 1'b0;
        end
        wclk(H);
        cs_n = 1'b1;
        wclk(2*H);
        rd_window = 1'b0;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        logic [15:0] g;
        xfer({2'b01, a, d}, 16, 0, g);
        if (hit(a)) mdl[idx(a)] = d;
    endtask

    task automatic do_read(input logic [5:0] a, input string tag);
        logic [15:0] g;
        logic [7:0] e;
        xfer({2'b10, a, 8'h00}, 16, 8, g);
        e = exp_read(a);
        chk(g[15:8] === e, tag, 128'(g[15:8]), 128'(e));
    endtask

    task automatic pulse(input bit p);
        @(negedge clk);
        if (p) pcal_ack = 1'b1; else fcal_ack = 1'b1;
        @(negedge clk);
        pcal_ack = 1'b0; fcal_ack = 1'b0;
        if (p) mdl[1][3] = 1'b0; else mdl[1][2] = 1'b0;
        wclk(4);
    endtask

    initial begin
        logic [15:0] g;
        void'($urandom(32'd20240611));
        model_reset();
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        // R11 reset state
        chk(cfg_flat === exp_flat(), "R11 reset contents", cfg_flat, exp_flat());
        chk(sdio_oe === 1'b0, "R11 output enable after reset", 128'(sdio_oe), 128'(0));

        // R2 / R1 directed store and fetch
        do_write(6'h02, 8'hA5);
        chk(cfg_flat === exp_flat(), "R2 store 0x02", cfg_flat, exp_flat());
        do_read(6'h02, "R1 fetch 0x02");
        do_write(6'h10, 8'h3C);
        chk(cfg_flat[127:120] === 8'h3C, "R2 store 0x10 index 15", 128'(cfg_flat[127:120]), 128'h3C);

        // R3 read-out repeats
        xfer({2'b10, 6'h10, 8'h00}, 16, 16, g);
        chk(g === {8'h3C, 8'h3C}, "R3 repeated read-out", 128'(g), 128'h3C3C);

        // R4 nop
        xfer({2'b00, 6'h02, 8'hFF}, 16, 0, g);
        chk(cfg_flat === exp_flat(), "R4 nop leaves registers", cfg_flat, exp_flat());

        // R7 status
        st_lock = 1; st_gain_hi = 0; st_xtal_ok = 1; st_pcal_done = 0; st_fcal_done = 1;
        do_read(6'h1A, "R7 status map");
        do_write(6'h1A, 8'hFF);
        chk(cfg_flat === exp_flat(), "R7 store to status ignored", cfg_flat, exp_flat());
        do_read(6'h1A, "R7 status after store");

        // R9 unimplemented
        do_write(6'h04, 8'h77);
        do_write(6'h11, 8'h77);
        do_write(6'h3F, 8'h77);
        chk(cfg_flat === exp_flat(), "R9 stores ignored", cfg_flat, exp_flat());
        do_read(6'h04, "R9 fetch 0x04 is zero");
        do_read(6'h2B, "R9 fetch 0x2B is zero");

        // R8 self-clearing requests
        do_write(6'h01, 8'h8C);
        do_read(6'h01, "R8 control set");
        pulse(1'b1);
        chk(cfg_flat[15:8] === mdl[1], "R8 polling request cleared", 128'(cfg_flat[15:8]), 128'(mdl[1]));
        pulse(1'b0);
        do_read(6'h01, "R8 both requests cleared");

        // R10 abort
        do_write(6'h03, 8'h55);
        xfer({2'b01, 6'h03, 8'hAA}, 12, 0, g);
        chk(cfg_flat === exp_flat(), "R10 abort after 12 bits", cfg_flat, exp_flat());
        xfer({2'b01, 6'h03, 8'hAA}, 15, 0, g);
        chk(cfg_flat === exp_flat(), "R10 abort after 15 bits", cfg_flat, exp_flat());
        do_read(6'h03, "R10 frame after abort");

        // R5 global restore
        do_write(6'h01, 8'h0C);
        do_write(6'h05, 8'h11);
        xfer({2'b11, 6'h00, 8'h00}, 16, 0, g);
        model_reset();
        chk(cfg_flat === exp_flat(), "R5 restore defaults", cfg_flat, exp_flat());

        // random mix
        for (int k = 0; k < 110; k++) begin
            int r;
            logic [5:0] a;
            logic [7:0] d;
            r = int'($urandom % 12);
            a = ($urandom % 3 == 0) ? 6'($urandom % 64) : 6'($urandom % 18);
            d = 8'($urandom);
            {st_lock, st_gain_hi, st_xtal_ok, st_pcal_done, st_fcal_done} = 5'($urandom);
            if (r < 6) begin
                do_write(a, d);
                chk(cfg_flat === exp_flat(), "R2 random store", cfg_flat, exp_flat());
            end else if (r < 9) begin
                do_read(a, "R3 random fetch");
            end else if (r == 9) begin
                xfer({2'b00, a, d}, 16, 0, g);
                chk(cfg_flat === exp_flat(), "R4 random nop", cfg_flat, exp_flat());
            end else if (r == 10) begin
                do_read(6'h1A, "R7 random status");
            end else begin
                if (k % 4 == 0) begin
                    xfer({2'b11, a, d}, 16, 0, g);
                    model_reset();
                    chk(cfg_flat === exp_flat(), "R5 random restore", cfg_flat, exp_flat());
                end else begin
                    xfer({2'b01, a, d}, 1 + int'($urandom % 15), 0, g);
                    chk(cfg_flat === exp_flat(), "R10 random abort", cfg_flat, exp_flat());
                end
            end
        end

        chk(oe_viol == 0, "R6 drive outside read window", 128'(oe_viol), 128'(0));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule